// File: doc/BRIEF.md
# Operand Addressing Mode Unit

This block resolves a single source operand for a register-memory ALU instruction. It is handed an already decoded request: a 4-bit mode code, a base register number, an index register number, a constant/displacement field, a 2-bit element-size code and a flag saying whether the operand is being used as a destination. It reads the two named registers through an external combinational register-file read port, forms an effective address, and issues word reads on a synchronous memory port whose data returns one cycle after the read strobe.

A five-state sequencer (idle, address, first memory cycle, second memory cycle, done) walks each request through the cycles it needs. Immediate and register operands finish without touching memory, most memory modes take one read, and memory-indirect takes two back-to-back reads, the second at the word returned by the first. Auto-increment and auto-decrement modes also produce a base-register write-back, presented in the same cycle as the done strobe. An undefined mode, or an immediate requested as a destination, ends in an error strobe with no memory traffic.

Top module: `opnd_resolver`

## Requirements
- R1: Mode 0 (immediate) returns req_const as the operand with no memory read; done is seen on the second clock after the request is accepted.
- R2: Mode 0 with req_dst high raises err (never done), issues no memory read and no write-back, two clocks after acceptance.
- R3: Mode 1 (register) returns the base register value with no memory read, done two clocks after acceptance.
- R4: Mode 2 (absolute) makes one read at the low ABS_W bits of req_const, zero-extended, so upper constant bits are ignored; done three clocks after acceptance with the read data.
- R5: One read, done three clocks after acceptance, at: mode 3 the base value; mode 4 base plus index; mode 5 constant plus base (all modulo 2^DATA_W).
- R6: Mode 6 (memory-indirect) reads at the base value, then on the next cycle reads at the word returned; the operand is the second word and done comes four clocks after acceptance.
- R7: Mode 7 (auto-increment) reads at the current base value and writes back base + d, where d is 1, 2, 4 or 8 for size codes 0, 1, 2, 3.
- R8: Mode 8 (auto-decrement) reads at base - d and writes back base - d.
- R9: Mode 9 (scaled) reads at constant + base + index × d, d as in R7.
- R10: Mode codes 10 to 15 raise err two clocks after acceptance, with no memory read and no write-back.
- R11: wb_en is high only in the done cycle of modes 7 and 8; wb_reg then carries the base register number and wb_data the updated base.
- R12: req_ready is high only while idle; a request is taken only then, and changes on the request inputs while busy do not affect the result in progress. done and err are never high together and are one-cycle strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Unit idle, request taken this cycle if valid |
| req_mode | input | 4 | Addressing mode code |
| req_dst | input | 1 | Operand is used as a destination |
| req_base | input | REG_AW (3) | Base register number |
| req_index | input | REG_AW (3) | Index register number |
| req_const | input | DATA_W (16) | Constant, absolute address or displacement |
| req_size | input | 2 | Element size code, d = 1 << code |
| rf_base_sel | output | REG_AW (3) | Register-file read select for the base |
| rf_index_sel | output | REG_AW (3) | Register-file read select for the index |
| rf_base_val | input | DATA_W (16) | Base register contents (combinational) |
| rf_index_val | input | DATA_W (16) | Index register contents (combinational) |
| mem_rd_en | output | 1 | Memory word read strobe |
| mem_addr | output | DATA_W (16) | Memory read address |
| mem_rdata | input | DATA_W (16) | Read data, valid the cycle after mem_rd_en |
| done | output | 1 | Operand ready strobe |
| err | output | 1 | Illegal or undefined request strobe |
| operand | output | DATA_W (16) | Resolved operand, valid with done |
| wb_en | output | 1 | Base-register write-back valid |
| wb_reg | output | REG_AW (3) | Write-back register number |
| wb_data | output | DATA_W (16) | Write-back value |

## Verification
On every cycle the assertions check the sequencing rules: done and err never coincide, a write-back never appears without done, an error never follows a memory read, every read happens while the unit is busy, the second indirect fetch always follows a first one, and each completion returns the unit to idle. What they cannot see is whether the numbers are right, so the bench's directed and seeded random requests compare each effective address, the read count, the operand, the write-back value and the completion latency against its own model of all ten modes, including wrap-around on decrement, truncated absolute addresses, all four size codes and request inputs that change while the unit is busy.

// File: rtl/opnd_pkg.sv
package opnd_pkg;

  localparam logic [3:0] M_IMM   = 4'd0;
  localparam logic [3:0] M_REG   = 4'd1;
  localparam logic [3:0] M_ABS   = 4'd2;
  localparam logic [3:0] M_RIND  = 4'd3;
  localparam logic [3:0] M_RIDX  = 4'd4;
  localparam logic [3:0] M_RDISP = 4'd5;
  localparam logic [3:0] M_MIND  = 4'd6;
  localparam logic [3:0] M_AINC  = 4'd7;
  localparam logic [3:0] M_ADEC  = 4'd8;
  localparam logic [3:0] M_SCALE = 4'd9;

  typedef enum logic [2:0] {
    S_IDLE = 3'd0,
    S_ADDR = 3'd1,
    S_MEM1 = 3'd2,
    S_MEM2 = 3'd3,
    S_DONE = 3'd4
  } seq_state_e;

endpackage

// File: rtl/opnd_agen.sv
module opnd_agen
  import opnd_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ABS_W  = 8
) (
  input  logic [3:0]        mode,
  input  logic [1:0]        size,
  input  logic [DATA_W-1:0] cst,
  input  logic [DATA_W-1:0] base_v,
  input  logic [DATA_W-1:0] idx_v,
  output logic [DATA_W-1:0] ea,
  output logic [DATA_W-1:0] wb_val,
  output logic [DATA_W-1:0] direct_val,
  output logic              mode_ok,
  output logic              uses_mem,
  output logic              two_reads,
  output logic              has_wb
);

  localparam logic [DATA_W-1:0] ABS_MASK = {{(DATA_W-ABS_W){1'b0}}, {ABS_W{1'b1}}};

  function automatic logic [DATA_W-1:0] elem_step(input logic [1:0] sz);
    return {{(DATA_W-1){1'b0}}, 1'b1} << sz;
  endfunction

  function automatic logic [DATA_W-1:0] scale_idx(input logic [DATA_W-1:0] v,
                                                  input logic [1:0] sz);
    return v << sz;
  endfunction

  function automatic logic [DATA_W-1:0] abs_addr(input logic [DATA_W-1:0] c);
    return c & ABS_MASK;
  endfunction

  always_comb begin
    ea         = base_v;
    wb_val     = base_v;
    direct_val = cst;
    mode_ok    = 1'b1;
    uses_mem   = 1'b1;
    two_reads  = 1'b0;
    has_wb     = 1'b0;
    case (mode)
      M_IMM:   uses_mem = 1'b0;
      M_REG:   begin uses_mem = 1'b0; direct_val = base_v; end
      M_ABS:   ea = abs_addr(cst);
      M_RIND:  ea = base_v;
      M_RIDX:  ea = base_v + idx_v;
      M_RDISP: ea = cst + base_v;
      M_MIND:  begin ea = base_v; two_reads = 1'b1; end
      M_AINC:  begin ea = base_v; wb_val = base_v + elem_step(size); has_wb = 1'b1; end
      M_ADEC:  begin ea = base_v - elem_step(size); wb_val = base_v - elem_step(size); has_wb = 1'b1; end
      M_SCALE: ea = cst + base_v + scale_idx(idx_v, size);
      default: begin mode_ok = 1'b0; uses_mem = 1'b0; end
    endcase
  end

endmodule

// File: rtl/opnd_seq.sv
module opnd_seq
  import opnd_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int REG_AW = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [3:0]        req_mode,
  input  logic              req_dst,
  input  logic [REG_AW-1:0] req_base,
  input  logic [REG_AW-1:0] req_index,
  input  logic [DATA_W-1:0] req_const,
  input  logic [1:0]        req_size,
  output logic              req_ready,
  output logic [3:0]        lat_mode,
  output logic [REG_AW-1:0] lat_base,
  output logic [REG_AW-1:0] lat_index,
  output logic [DATA_W-1:0] lat_const,
  output logic [1:0]        lat_size,
  input  logic [DATA_W-1:0] ea,
  input  logic [DATA_W-1:0] wb_val,
  input  logic [DATA_W-1:0] direct_val,
  input  logic              mode_ok,
  input  logic              uses_mem,
  input  logic              two_reads,
  input  logic              has_wb,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              mem_rd_en,
  output logic [DATA_W-1:0] mem_addr,
  output logic              first_fetch,
  output logic              second_fetch,
  output logic              done,
  output logic              err,
  output logic [DATA_W-1:0] operand,
  output logic              wb_en,
  output logic [DATA_W-1:0] wb_data
);

  seq_state_e        state;
  logic              lat_dst;
  logic              err_q;
  logic              wb_q;
  logic              bad_req;
  logic [DATA_W-1:0] operand_q;
  logic [DATA_W-1:0] wb_data_q;

  assign bad_req      = !mode_ok || (lat_dst && (lat_mode == M_IMM));
  assign first_fetch  = (state == S_ADDR) && uses_mem && !bad_req;
  assign second_fetch = (state == S_MEM1) && two_reads;
  assign mem_rd_en    = first_fetch || second_fetch;
  assign mem_addr     = second_fetch ? mem_rdata : ea;

  assign req_ready = (state == S_IDLE);
  assign done      = (state == S_DONE) && !err_q;
  assign err       = (state == S_DONE) && err_q;
  assign wb_en     = done && wb_q;
  assign operand   = operand_q;
  assign wb_data   = wb_data_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      lat_mode  <= '0;
      lat_dst   <= 1'b0;
      lat_base  <= '0;
      lat_index <= '0;
      lat_const <= '0;
      lat_size  <= '0;
      err_q     <= 1'b0;
      wb_q      <= 1'b0;
      operand_q <= '0;
      wb_data_q <= '0;
    end else begin
      case (state)
        S_IDLE: begin
          if (req_valid) begin
            lat_mode  <= req_mode;
            lat_dst   <= req_dst;
            lat_base  <= req_base;
            lat_index <= req_index;
            lat_const <= req_const;
            lat_size  <= req_size;
            err_q     <= 1'b0;
            wb_q      <= 1'b0;
            state     <= S_ADDR;
          end
        end
        S_ADDR: begin
          wb_q      <= has_wb && !bad_req;
          wb_data_q <= wb_val;
          if (bad_req) begin
            err_q <= 1'b1;
            state <= S_DONE;
          end else if (!uses_mem) begin
            operand_q <= direct_val;
            state     <= S_DONE;
          end else begin
            state <= S_MEM1;
          end
        end
        S_MEM1: begin
          if (two_reads) begin
            state <= S_MEM2;
          end else begin
            operand_q <= mem_rdata;
            state     <= S_DONE;
          end
        end
        S_MEM2: begin
          operand_q <= mem_rdata;
          state     <= S_DONE;
        end
        S_DONE:  state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/opnd_resolver.sv
module opnd_resolver
  import opnd_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int REG_AW = 3,
  parameter int ABS_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [3:0]        req_mode,
  input  logic              req_dst,
  input  logic [REG_AW-1:0] req_base,
  input  logic [REG_AW-1:0] req_index,
  input  logic [DATA_W-1:0] req_const,
  input  logic [1:0]        req_size,
  output logic [REG_AW-1:0] rf_base_sel,
  output logic [REG_AW-1:0] rf_index_sel,
  input  logic [DATA_W-1:0] rf_base_val,
  input  logic [DATA_W-1:0] rf_index_val,
  output logic              mem_rd_en,
  output logic [DATA_W-1:0] mem_addr,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              done,
  output logic              err,
  output logic [DATA_W-1:0] operand,
  output logic              wb_en,
  output logic [REG_AW-1:0] wb_reg,
  output logic [DATA_W-1:0] wb_data
);

  logic [3:0]        lat_mode;
  logic [REG_AW-1:0] lat_base;
  logic [REG_AW-1:0] lat_index;
  logic [DATA_W-1:0] lat_const;
  logic [1:0]        lat_size;
  logic [DATA_W-1:0] ea;
  logic [DATA_W-1:0] wb_val;
  logic [DATA_W-1:0] direct_val;
  logic              mode_ok;
  logic              uses_mem;
  logic              two_reads;
  logic              has_wb;
  logic              first_fetch;
  logic              second_fetch;

  assign rf_base_sel  = lat_base;
  assign rf_index_sel = lat_index;
  assign wb_reg       = lat_base;

  opnd_agen #(.DATA_W(DATA_W), .ABS_W(ABS_W)) u_agen (
    .mode       (lat_mode),
    .size       (lat_size),
    .cst        (lat_const),
    .base_v     (rf_base_val),
    .idx_v      (rf_index_val),
    .ea         (ea),
    .wb_val     (wb_val),
    .direct_val (direct_val),
    .mode_ok    (mode_ok),
    .uses_mem   (uses_mem),
    .two_reads  (two_reads),
    .has_wb     (has_wb)
  );

  opnd_seq #(.DATA_W(DATA_W), .REG_AW(REG_AW)) u_seq (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (req_valid),
    .req_mode     (req_mode),
    .req_dst      (req_dst),
    .req_base     (req_base),
    .req_index    (req_index),
    .req_const    (req_const),
    .req_size     (req_size),
    .req_ready    (req_ready),
    .lat_mode     (lat_mode),
    .lat_base     (lat_base),
    .lat_index    (lat_index),
    .lat_const    (lat_const),
    .lat_size     (lat_size),
    .ea           (ea),
    .wb_val       (wb_val),
    .direct_val   (direct_val),
    .mode_ok      (mode_ok),
    .uses_mem     (uses_mem),
    .two_reads    (two_reads),
    .has_wb       (has_wb),
    .mem_rdata    (mem_rdata),
    .mem_rd_en    (mem_rd_en),
    .mem_addr     (mem_addr),
    .first_fetch  (first_fetch),
    .second_fetch (second_fetch),
    .done         (done),
    .err          (err),
    .operand      (operand),
    .wb_en        (wb_en),
    .wb_data      (wb_data)
  );

endmodule

// File: rtl/opnd_resolver_chk.sv
module opnd_resolver_chk (
  input logic clk,
  input logic rst_n,
  input logic req_ready,
  input logic mem_rd_en,
  input logic done,
  input logic err,
  input logic wb_en,
  input logic first_fetch,
  input logic second_fetch
);

  a_r12_strobes_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && err));

  a_r12_finish_returns_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (done || err) |=> req_ready);

  a_r12_read_only_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_en |-> !req_ready);

  a_r11_wb_needs_done: assert property (@(posedge clk) disable iff (!rst_n)
    wb_en |-> done);

  a_r10_err_without_read: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> !$past(mem_rd_en));

  a_r6_second_after_first: assert property (@(posedge clk) disable iff (!rst_n)
    second_fetch |-> $past(first_fetch));

endmodule

bind opnd_resolver opnd_resolver_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .req_ready    (req_ready),
  .mem_rd_en    (mem_rd_en),
  .done         (done),
  .err          (err),
  .wb_en        (wb_en),
  .first_fetch  (first_fetch),
  .second_fetch (second_fetch)
);

// File: tb/opnd_resolver_tb.sv
`timescale 1ns/1ps
module opnd_resolver_tb;

  localparam int DW = 16;
  localparam int RW = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic [3:0]    req_mode = '0;
  logic          req_dst = 1'b0;
  logic [RW-1:0] req_base = '0;
  logic [RW-1:0] req_index = '0;
  logic [DW-1:0] req_const = '0;
  logic [1:0]    req_size = '0;
  logic [RW-1:0] rf_base_sel, rf_index_sel;
  logic [DW-1:0] rf_base_val, rf_index_val;
  logic          mem_rd_en;
  logic [DW-1:0] mem_addr;
  logic [DW-1:0] mem_rdata = '0;
  logic          done, err, wb_en;
  logic [DW-1:0] operand, wb_data;
  logic [RW-1:0] wb_reg;

  logic [DW-1:0] rf [8];
  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  assign rf_base_val  = rf[rf_base_sel];
  assign rf_index_val = rf[rf_index_sel];

  function automatic logic [DW-1:0] memf(input logic [DW-1:0] a);
    logic [31:0] t;
    t = {16'd0, a} * 32'h9E37;
    return t[15:0] ^ 16'h5A5A;
  endfunction

  always_ff @(posedge clk) mem_rdata <= memf(mem_addr);

  opnd_resolver u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_mode(req_mode), .req_dst(req_dst), .req_base(req_base),
    .req_index(req_index), .req_const(req_const), .req_size(req_size),
    .rf_base_sel(rf_base_sel), .rf_index_sel(rf_index_sel),
    .rf_base_val(rf_base_val), .rf_index_val(rf_index_val),
    .mem_rd_en(mem_rd_en), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
    .done(done), .err(err), .operand(operand), .wb_en(wb_en),
    .wb_reg(wb_reg), .wb_data(wb_data)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic string tag_of(input logic [3:0] m, input logic dst);
    case (m)
      4'd0: return dst ? "R2" : "R1";
      4'd1: return "R3";
      4'd2: return "R4";
      4'd3, 4'd4, 4'd5: return "R5";
      4'd6: return "R6";
      4'd7: return "R7";
      4'd8: return "R8";
      4'd9: return "R9";
      default: return "R10";
    endcase
  endfunction

  function automatic logic [DW-1:0] elem(input logic [1:0] sz);
    case (sz)
      2'd0: return 16'd1;
      2'd1: return 16'd2;
      2'd2: return 16'd4;
      default: return 16'd8;
    endcase
  endfunction

  task automatic run_op(input logic [3:0] m, input logic dst, input logic [RW-1:0] bn,
                        input logic [RW-1:0] xn, input logic [DW-1:0] c,
                        input logic [1:0] sz, input bit hold);
    logic [DW-1:0] b, x, a1, opv, wbv;
    logic          xerr, xwb;
    int            nrd, lat, rds;
    logic [DW-1:0] ra [2];
    bit            ready_busy;
    string         tg;
    for (int i = 0; i < 8; i++) rf[i] = 16'($urandom);
    b = rf[bn]; x = rf[xn];
    xerr = 1'b0; xwb = 1'b0; nrd = 1; a1 = '0; wbv = '0; opv = '0;
    case (m)
      4'd0: begin nrd = 0; opv = c; xerr = dst; end
      4'd1: begin nrd = 0; opv = b; end
      4'd2: a1 = {8'h00, c[7:0]};
      4'd3: a1 = b;
      4'd4: a1 = 16'(b + x);
      4'd5: a1 = 16'(c + b);
      4'd6: begin nrd = 2; a1 = b; end
      4'd7: begin a1 = b; xwb = 1'b1; wbv = 16'(b + elem(sz)); end
      4'd8: begin a1 = 16'(b - elem(sz)); xwb = 1'b1; wbv = a1; end
      4'd9: a1 = 16'(c + b + 16'(x * elem(sz)));
      default: begin nrd = 0; xerr = 1'b1; end
    endcase
    if (xerr) nrd = 0;
    if (nrd == 1) opv = memf(a1);
    if (nrd == 2) opv = memf(memf(a1));
    tg = tag_of(m, dst);

    @(negedge clk);
    chk("R12 ready when idle", 32'(req_ready), 32'd1);
    req_valid = 1'b1; req_mode = m; req_dst = dst; req_base = bn;
    req_index = xn; req_const = c; req_size = sz;
    lat = 0; rds = 0; ra[0] = '0; ra[1] = '0; ready_busy = 0;
    forever begin
      @(negedge clk);
      lat++;
      if (!hold) req_valid = 1'b0;
      else begin
        req_mode = 4'($urandom); req_const = 16'($urandom);
        req_base = 3'($urandom); req_size = 2'($urandom); req_dst = 1'($urandom);
      end
      if (req_ready) ready_busy = 1;
      if (mem_rd_en) begin
        if (rds < 2) ra[rds] = mem_addr;
        rds++;
      end
      if (done || err || lat > 10) break;
    end
    req_valid = 1'b0;

    chk({tg, " done"}, 32'(done), 32'(!xerr));
    chk({tg, " err"}, 32'(err), 32'(xerr));
    chk({tg, " latency"}, 32'(lat), 32'(2 + nrd));
    chk({tg, " read count"}, 32'(rds), 32'(nrd));
    if (nrd >= 1) chk({tg, " first address"}, 32'(ra[0]), 32'(a1));
    if (nrd == 2) chk("R6 second address", 32'(ra[1]), 32'(memf(a1)));
    if (!xerr) chk({tg, " operand"}, 32'(operand), 32'(opv));
    chk("R11 wb_en", 32'(wb_en), 32'(xwb));
    if (xwb) begin
      chk("R11 wb_reg", 32'(wb_reg), 32'(bn));
      chk("R11 wb_data", 32'(wb_data), 32'(wbv));
    end
    chk("R12 ready low while busy", 32'(ready_busy), 32'd0);
  endtask

  task automatic finish_run;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    int unsigned seed;
    seed = $urandom(32'd20240611);
    for (int i = 0; i < 8; i++) rf[i] = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    chk("R12 reset ready", 32'(req_ready), 32'd1);
    chk("R12 reset done", 32'(done), 32'd0);
    chk("R10 reset err", 32'(err), 32'd0);
    chk("R11 reset wb_en", 32'(wb_en), 32'd0);
    chk("R12 reset no read", 32'(mem_rd_en), 32'd0);

    // directed: every defined mode, each size code, corner values
    run_op(4'd0, 1'b0, 3'd1, 3'd2, 16'h1234, 2'd0, 0);   // R1
    run_op(4'd0, 1'b1, 3'd1, 3'd2, 16'h1234, 2'd0, 0);   // R2 immediate as destination
    run_op(4'd1, 1'b1, 3'd5, 3'd2, 16'h0000, 2'd0, 0);   // R3
    run_op(4'd2, 1'b0, 3'd0, 3'd0, 16'hABCD, 2'd0, 0);   // R4 upper bits dropped
    run_op(4'd3, 1'b0, 3'd3, 3'd4, 16'h0000, 2'd0, 0);   // R5
    run_op(4'd4, 1'b0, 3'd3, 3'd3, 16'h0000, 2'd0, 0);   // R5 same register
    run_op(4'd5, 1'b0, 3'd6, 3'd1, 16'hFFF0, 2'd0, 0);   // R5
    run_op(4'd6, 1'b0, 3'd7, 3'd0, 16'h0000, 2'd0, 0);   // R6
    for (int s = 0; s < 4; s++) begin
      run_op(4'd7, 1'b0, 3'd2, 3'd0, 16'h0, 2'(s), 0);   // R7
      run_op(4'd8, 1'b0, 3'd2, 3'd0, 16'h0, 2'(s), 0);   // R8
      run_op(4'd9, 1'b0, 3'd2, 3'd4, 16'h0100, 2'(s), 0); // R9
    end
    for (int m = 10; m < 16; m++) run_op(4'(m), 1'b0, 3'd1, 3'd1, 16'h55, 2'd1, 0); // R10
    run_op(4'd6, 1'b0, 3'd4, 3'd5, 16'h0, 2'd3, 1);      // R12 inputs change while busy
    run_op(4'd8, 1'b0, 3'd0, 3'd5, 16'h0, 2'd2, 1);      // R12
    run_op(4'd1, 1'b0, 3'd6, 3'd5, 16'h0, 2'd2, 1);      // R12

    // seeded random mix
    for (int n = 0; n < 400; n++)
      run_op(4'($urandom), 1'($urandom_range(0, 3) == 0), 3'($urandom), 3'($urandom),
             16'($urandom), 2'($urandom), bit'($urandom_range(0, 4) == 0));

    repeat (2) @(negedge clk);
    finish_run();
  end

endmodule